// File: doc/BRIEF.md
# Reversible Toffoli-Cascade Binary Up Counter

This block is a synchronous binary up counter with a parameterised number of state bits. Its next-state function is a strictly reversible network. The network is a chain of multi-control Toffoli gates that rewrites the state lines in place. The count-enable line travels through the network unchanged and acts as a control on every gate. A plain register samples the network's state lines and feeds them back, and a synchronous reset clears that register.

The reversible core also sits in a combinational wrapper that exposes its complete input and output line vectors, so the core can be exercised on its own. The package computes elaboration-time constants for the quantum cost and garbage count of the cascade. It computes the same figures for the classical design that uses T flip-flops with AND gates, so the two can be compared.

Top module: `reversible_up_counter`

## Requirements
- R1: In the core line vector, bit 0 carries the enable and bit k+1 carries state bit k. Output state bit 0 equals input state bit 0 XOR the enable line.
- R2: For each state bit i above 0, the output bit equals the input bit XOR (enable AND all input state bits below i). Each such term is one Toffoli gate with i+1 controls.
- R3: The core's output enable line (bit 0) always equals its input enable line.
- R4: The core is a bijection: no two of the 2^(N+1) input vectors produce the same output vector.
- R5: When `en` is 0 and `rst` is 0, `count` keeps its value across the clock edge.
- R6: When `en` is 1 and `rst` is 0, `count` advances by one modulo 2^N at each clock edge, so all ones wraps to zero.
- R7: A high `rst` at a clock edge sets `count` to zero, whatever the value of `en`.
- R8: The gates are applied from the most significant bit down, so every control sees the pre-edge value of the lower bits. For example, 0111 with enable high goes to 1000 in one edge.
- R9: For the cascade, the cost tally gives 19 for 3 bits and 35 for 4 bits, with a garbage count of 1. For the flip-flop replacement design it gives 24 for 3 bits and 40 for 4 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to zero |
| en | input | 1 | Count enable, the control line of the reversible network |
| count | output | N | Current counter value |

## Verification
The core is driven exhaustively through every input vector, with the enable line both low and high. This shows each bit's toggle condition separately (R1, R2) and exposes any collision in the mapping (R4). The registered counter is then stepped through several patterns:
- A run of steady enables covers two full wrap-arounds and the carry ripple through 0111.
- Random enable patterns separate the hold case from the advance case.
- Reset is asserted together with the enable to show that reset wins.

// File: rtl/rev_count_pkg.sv
package rev_count_pkg;

    localparam int DEFAULT_BITS = 4;

    // Quantum cost of one Toffoli gate, indexed by its number of controls.
    function automatic int mct_cost(input int nctrl);
        int c;
        if (nctrl <= 1)      c = 1;
        else if (nctrl == 2) c = 5;
        else if (nctrl == 3) c = 13;
        else                 c = 16 * (nctrl - 3);
        return c;
    endfunction

    // Direct cascade: the gate for bit i has i+1 controls.
    function automatic int direct_cost(input int nbits);
        int acc;
        acc = 0;
        for (int i = 0; i < nbits; i++) acc += mct_cost(i + 1);
        return acc;
    endfunction

    // Classical design rebuilt from reversible flip-flop and AND replacements.
    function automatic int repl_cost(input int nbits);
        int c;
        if (nbits <= 2) c = 8 * nbits;
        else            c = 16 * nbits - 24;
        return c;
    endfunction

    // The only surplus output of the cascade is the echoed enable line.
    function automatic int direct_garbage(input int nbits);
        return (nbits > 0) ? 1 : 0;
    endfunction

    // Golden reference for one gate application on a line vector.
    function automatic logic gate_flip(input logic [31:0] lines, input int tgt);
        logic all_ones;
        all_ones = 1'b1;
        for (int k = 0; k < 32; k++)
            if (k < tgt) all_ones &= lines[k];
        return all_ones;
    endfunction

endpackage

// File: rtl/rc_mct_gate.sv
module rc_mct_gate #(
    parameter int LINES = 5,
    parameter int TGT   = 1
) (
    input  logic [LINES-1:0] a,
    output logic [LINES-1:0] y
);
    localparam int NCTRL = TGT;

    logic ctrl_all;

    always_comb begin
        ctrl_all = &a[NCTRL-1:0];
        y        = a;
        y[TGT]   = a[TGT] ^ ctrl_all;
    end

    // R3 (gate level): all lines other than the target pass through.
    always_comb begin
        if (!$isunknown(a)) begin
            for (int k = 0; k < LINES; k++)
                if (k != TGT)
                    gate_pass_chk: assert (y[k] == a[k]);
        end
    end
endmodule

// File: rtl/rc_cascade.sv
module rc_cascade #(
    parameter int N = rev_count_pkg::DEFAULT_BITS
) (
    input  logic [N:0] lines_in,
    output logic [N:0] lines_out
);
    import rev_count_pkg::*;

    localparam int LINES   = N + 1;
    localparam int COST    = direct_cost(N);
    localparam int GARBAGE = direct_garbage(N);

    logic [LINES-1:0] stage [0:N];

    assign stage[0] = lines_in;

    // R8: gate g targets line N-g, so the MSB is rewritten first and the
    // lower lines are still at their time-t values when they act as controls.
    for (genvar g = 0; g < N; g++) begin : g_gate
        rc_mct_gate #(.LINES(LINES), .TGT(N - g)) u_gate (
            .a (stage[g]),
            .y (stage[g+1])
        );
    end

    assign lines_out = stage[N];

    always_comb begin
        if (!$isunknown(lines_in)) begin
            // R3
            enable_echo_chk: assert (lines_out[0] == lines_in[0]);
            // R5
            idle_identity_chk: assert (lines_in[0] || lines_out == lines_in);
        end
    end
endmodule

// File: rtl/rc_core_wrap.sv
module rc_core_wrap #(
    parameter int N = rev_count_pkg::DEFAULT_BITS
) (
    input  logic [N:0] lines_in,
    output logic [N:0] lines_out
);
    rc_cascade #(.N(N)) u_cascade (
        .lines_in  (lines_in),
        .lines_out (lines_out)
    );
endmodule

// File: rtl/rc_state_reg.sv
module rc_state_reg #(
    parameter int N = rev_count_pkg::DEFAULT_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R7
    reset_clear_chk: assert property (@(posedge clk) rst |=> q == '0);
endmodule

// File: rtl/reversible_up_counter.sv
module reversible_up_counter #(
    parameter int N = rev_count_pkg::DEFAULT_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [N-1:0] count
);
    typedef struct packed {
        logic [N-1:0] q;
        logic         c;
    } line_t;

    line_t        core_in;
    line_t        core_out;
    logic [N-1:0] state_q;

    assign core_in = '{q: state_q, c: en};

    rc_core_wrap #(.N(N)) u_core (
        .lines_in  (core_in),
        .lines_out (core_out)
    );

    rc_state_reg #(.N(N)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (core_out.q),
        .q   (state_q)
    );

    assign count = state_q;

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));
    // R6
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> count == N'($past(count) + 1'b1));
    // R6
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (en && count == '1) |=> count == '0);
endmodule

// File: tb/reversible_up_counter_test.sv
module reversible_up_counter_test;
    import rev_count_pkg::*;

    localparam int  N          = 4;
    localparam time CLK_PERIOD = 10;

    typedef struct {
        logic [N-1:0] exp;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [N-1:0] count;
    logic [N:0]   w_in = '0;
    logic [N:0]   w_out;

    int applied = 0;
    int miscmp  = 0;
    logic [N-1:0] model = '0;
    item_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    reversible_up_counter #(.N(N)) uut (
        .clk (clk), .rst (rst), .en (en), .count (count)
    );

    rc_core_wrap #(.N(N)) core_uut (.lines_in (w_in), .lines_out (w_out));

    task automatic check(input string req, input int act, input int exp);
        applied++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: sets inputs for the next rising edge and records the expectation.
    task automatic step(input logic r, input logic e, input string req);
        item_t it;
        @(negedge clk);
        rst = r;
        en  = e;
        if (r)      model = '0;
        else if (e) model = N'(model + 1'b1);
        it.exp = model;
        it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compares once the register has settled after each edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.req, int'(count), int'(it.exp));
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        miscmp++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        bit seen [0:(1<<(N+1))-1];
        for (int v = 0; v < (1 << (N+1)); v++) seen[v] = 1'b0;

        // R1 R2 R3 R4: exhaustive core sweep
        for (int v = 0; v < (1 << (N+1)); v++) begin
            logic [N:0] exp_v;
            w_in = (N+1)'(v);
            #1;
            exp_v = w_in;
            for (int i = 0; i < N; i++) begin
                logic lower;
                lower = w_in[0];
                for (int j = 0; j < i; j++) lower &= w_in[j+1];
                exp_v[i+1] = w_in[i+1] ^ lower;
            end
            check("R1", int'(w_out[1]), int'(exp_v[1]));
            check("R2", int'(w_out), int'(exp_v));
            check("R3", int'(w_out[0]), int'(w_in[0]));
            check("R4", int'(seen[w_out]), 0);
            seen[w_out] = 1'b1;
        end

        // R9: cost tally
        check("R9", direct_cost(3), 19);
        check("R9", direct_cost(4), 35);
        check("R9", repl_cost(3), 24);
        check("R9", repl_cost(4), 40);
        check("R9", direct_garbage(4), 1);

        // R7: reset state, and reset beating enable
        step(1'b1, 1'b0, "R7");
        step(1'b1, 1'b1, "R7");

        // R8: 0111 -> 1000 in one edge
        for (int k = 0; k < 7; k++) step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b1, "R8");

        // R5: hold
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R5");

        // R6: two full wrap-arounds with steady enable
        for (int k = 0; k < 2 * (1 << N) + 2; k++) step(1'b0, 1'b1, "R6");

        // R5 R6: random enable pattern
        for (int k = 0; k < 120; k++) begin
            logic e;
            e = 1'($urandom_range(0, 1));
            step(1'b0, e, e ? "R6" : "R5");
        end

        // R7: reset mid-count with enable high
        step(1'b1, 1'b1, "R7");
        step(1'b0, 1'b1, "R6");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule